// File: doc/BRIEF.md
# Multi-Write, Multi-Read Port RAM with Invalidation Table

This block is a memory with several independent write ports and several independent read ports. It is assembled only from simple dual-port arrays, each with one write port and one read port, so it maps onto ordinary FPGA block or distributed RAM. Every write port owns a data bank, and each bank is copied once per read port, so that every read port has a private copy of every bank. A read port fetches the same address from all of its copies and picks the one that holds the newest value.

A bank-selection table, also made only from one-write/one-read arrays, records which write port last wrote each address. No port overwrites another port's entry. Each writer stores a value in its own table bank, computed from the other ports' current entries at that address, and that value makes the older owners invalid. The table is kept in one of two encodings. In the binary form the entries of all banks are XOR-combined into the index of the owning port. In the one-hot form each pair of ports keeps an ordering bit, and the port that is newer than all others is the owner. A parameter chooses the encoding.

Reads take one clock cycle. A read of an address that a write port updates in the same cycle returns the value from before that write. Two write ports writing the same address in the same cycle give an undefined result and are outside the contract.

Top module: `multiport_ram`

## Requirements
- R1: A read returns the value of the most recent completed write to that address, whichever write port made it.
- R2: Read data for the address presented in one cycle appears on that read port in the following cycle.
- R3: A read of an address that is being written in the same cycle returns the value from before that write, and the new value is returned from the next cycle on.
- R4: Writes on different ports to different addresses in the same cycle all take effect.
- R5: While rst is high, write enables are ignored and stored contents stay unchanged. Reads continue to work.
- R6: The encoding parameter enc takes ENC_BIN (1'b0) or ENC_ONEHOT (1'b1). Both give identical port behaviour, and in one-hot form at most one port is marked as owner of an address.
- R7: When a different port later rewrites an address, ownership moves to that port, in either port order and across repeated changes.
- R8: Read ports are independent. They may read the same address or different addresses in the same cycle, and each returns correct data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes while high |
| wr_en | input | NW | Write enable, one bit per write port |
| wr_addr | input | NW*AW | Write address per write port |
| wr_data | input | NW*DW | Write data per write port |
| rd_addr | input | NR*AW | Read address per read port |
| rd_data | output | NR*DW | Read data per read port, one cycle after its address |

## Verification
A corrupted table entry makes a read port choose the wrong bank copy. The port then returns the stale value last written by another port, and this shows on the next read of that address, one cycle after the address is presented. A missed or misplaced data-bank write shows the same way, but only on the one port's copy involved. For this reason every read port is compared against a shared array model after every cycle. Ownership is moved back and forth between ports in both index orders, which exercises the one-hot pair bits whose sense depends on port order.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

  typedef enum logic {
    ENC_BIN    = 1'b0,
    ENC_ONEHOT = 1'b1
  } lvt_enc_e;

  // Slot of port other_id inside the peer list kept by port self_id.
  function automatic int peer_pos(input int self_id, input int other_id);
    return (other_id < self_id) ? other_id : other_id - 1;
  endfunction

endpackage

// File: rtl/mpram_sdp.sv
module mpram_sdp #(
  parameter int DW       = 8,
  parameter int AW       = 4,
  parameter bit ASYNC_RD = 1'b0
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (ASYNC_RD) begin : g_async
      assign rdata = mem[raddr];
    end else begin : g_sync
      // read-before-write: same-edge write is not visible
      always_ff @(posedge clk) begin
        rdata <= mem[raddr];
      end
    end
  endgenerate

endmodule

// File: rtl/mpram_ilvt.sv
module mpram_ilvt
  import mpram_pkg::*;
#(
  parameter int       NW  = 3,
  parameter int       NR  = 2,
  parameter int       AW  = 4,
  parameter lvt_enc_e ENC = ENC_BIN,
  parameter int       SW  = $clog2(NW)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NW-1:0]          we,
  input  logic [NW-1:0][AW-1:0]  waddr,
  input  logic [NR-1:0][AW-1:0]  raddr,
  output logic [NR-1:0][SW-1:0]  sel
);
  localparam bit IS_BIN = (ENC == ENC_BIN);
  localparam int TW     = IS_BIN ? SW : NW - 1;  // stored entry width
  localparam int VW     = IS_BIN ? SW : 1;       // write-side copy width

  logic [NW-1:0][TW-1:0]         tnew;
  logic [NR-1:0][NW-1:0][TW-1:0] rview;

  generate
    for (genvar w = 0; w < NW; w++) begin : g_w
      logic [NW-2:0][VW-1:0] peer;
      logic [TW-1:0]         nv;

      for (genvar j = 0; j < NW; j++) begin : g_j
        if (j != w) begin : g_cp
          localparam int P = peer_pos(w, j);
          localparam int Q = peer_pos(j, w);
          logic [VW-1:0] cp_wd;
          if (IS_BIN) begin : g_b
            assign cp_wd = tnew[j];
          end else begin : g_o
            assign cp_wd = tnew[j][Q];
          end
          mpram_sdp #(.DW(VW), .AW(AW), .ASYNC_RD(1'b1)) i_peer (
            .clk(clk), .we(we[j]), .waddr(waddr[j]), .wdata(cp_wd),
            .raddr(waddr[w]), .rdata(peer[P])
          );
        end
      end

      if (IS_BIN) begin : g_nb
        always_comb begin
          nv = SW'(w);
          for (int p = 0; p < NW - 1; p++) nv ^= peer[p];
        end
      end else begin : g_no
        always_comb begin
          for (int p = 0; p < NW - 1; p++) nv[p] = peer[p][0] ^ (p >= w);
        end
      end
      assign tnew[w] = nv;

      for (genvar r = 0; r < NR; r++) begin : g_rc
        mpram_sdp #(.DW(TW), .AW(AW), .ASYNC_RD(1'b0)) i_rcopy (
          .clk(clk), .we(we[w]), .waddr(waddr[w]), .wdata(nv),
          .raddr(raddr[r]), .rdata(rview[r][w])
        );
      end
    end

    for (genvar r = 0; r < NR; r++) begin : g_rd
      logic [SW-1:0] s;
      if (IS_BIN) begin : g_db
        always_comb begin
          s = '0;
          for (int w = 0; w < NW; w++) s ^= rview[r][w];
        end
      end else begin : g_do
        logic [NW-1:0] valid;
        always_comb begin
          for (int w = 0; w < NW; w++) begin
            valid[w] = 1'b1;
            for (int j = 0; j < NW; j++) begin
              if (j < w)
                valid[w] &= (rview[r][w][peer_pos(w, j)] == rview[r][j][peer_pos(j, w)]);
              else if (j > w)
                valid[w] &= (rview[r][w][peer_pos(w, j)] != rview[r][j][peer_pos(j, w)]);
            end
          end
          s = '0;
          for (int w = 0; w < NW; w++) if (valid[w]) s |= SW'(w);
        end
        // R6
        owner_onehot0_chk: assert property (@(posedge clk) disable iff (rst)
          $onehot0(valid));
      end
      assign sel[r] = s;
    end
  endgenerate

  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NW; i++)
      for (int j = i + 1; j < NW; j++)
        if (we[i] && we[j] && waddr[i] == waddr[j]) clash = 1'b1;
  end

  generate
    for (genvar w = 0; w < NW; w++) begin : g_aw
      for (genvar r = 0; r < NR; r++) begin : g_ar
        // R7
        owner_moves_chk: assert property (@(posedge clk) disable iff (rst)
          $past(we[w] && !clash) && raddr[r] == $past(waddr[w]) |=> sel[r] == SW'(w));
      end
    end
  endgenerate

endmodule

// File: rtl/multiport_ram.sv
module multiport_ram
  import mpram_pkg::*;
#(
  parameter int       NW  = 3,
  parameter int       NR  = 2,
  parameter int       DW  = 16,
  parameter int       AW  = 4,
  parameter lvt_enc_e ENC = ENC_BIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NW-1:0]         wr_en,
  input  logic [NW-1:0][AW-1:0] wr_addr,
  input  logic [NW-1:0][DW-1:0] wr_data,
  input  logic [NR-1:0][AW-1:0] rd_addr,
  output logic [NR-1:0][DW-1:0] rd_data
);
  localparam int SW = $clog2(NW);

  logic [NW-1:0]                 weg;
  logic [NR-1:0][NW-1:0][DW-1:0] bank_q;
  logic [NR-1:0][SW-1:0]         sel;

  assign weg = wr_en & {NW{~rst}};

  mpram_ilvt #(.NW(NW), .NR(NR), .AW(AW), .ENC(ENC), .SW(SW)) i_table (
    .clk(clk), .rst(rst), .we(weg), .waddr(wr_addr), .raddr(rd_addr), .sel(sel)
  );

  generate
    for (genvar w = 0; w < NW; w++) begin : g_bank
      for (genvar r = 0; r < NR; r++) begin : g_copy
        mpram_sdp #(.DW(DW), .AW(AW), .ASYNC_RD(1'b0)) i_data (
          .clk(clk), .we(weg[w]), .waddr(wr_addr[w]), .wdata(wr_data[w]),
          .raddr(rd_addr[r]), .rdata(bank_q[r][w])
        );
      end
    end

    for (genvar r = 0; r < NR; r++) begin : g_mux
      logic [DW-1:0] d;
      always_comb begin
        d = '0;
        for (int w = 0; w < NW; w++) if (sel[r] == SW'(w)) d = bank_q[r][w];
      end
      assign rd_data[r] = d;
    end
  endgenerate

  logic [NR-1:0] rd_hit;
  logic          wr_clash;
  always_comb begin
    rd_hit   = '0;
    wr_clash = 1'b0;
    for (int r = 0; r < NR; r++)
      for (int w = 0; w < NW; w++)
        if (weg[w] && wr_addr[w] == rd_addr[r]) rd_hit[r] = 1'b1;
    for (int i = 0; i < NW; i++)
      for (int j = i + 1; j < NW; j++)
        if (weg[i] && weg[j] && wr_addr[i] == wr_addr[j]) wr_clash = 1'b1;
  end

  generate
    for (genvar r = 0; r < NR; r++) begin : g_ahold
      // R3
      read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(rd_addr[r]) && !$past(rd_hit[r]) |=> $stable(rd_data[r]));
      for (genvar w = 0; w < NW; w++) begin : g_awr
        // R1
        write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
          $past(weg[w] && !wr_clash) && rd_addr[r] == $past(wr_addr[w])
          |=> rd_data[r] == $past(wr_data[w], 2));
      end
    end
  endgenerate

endmodule

// File: tb/test_multiport_ram.sv
`timescale 1ns/1ps
module test_multiport_ram;
  import mpram_pkg::*;

  localparam int NW    = 3;
  localparam int NR    = 2;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [NW-1:0]         wr_en = '0;
  logic [NW-1:0][AW-1:0] wr_addr = '0;
  logic [NW-1:0][DW-1:0] wr_data = '0;
  logic [NR-1:0][AW-1:0] rd_addr = '0;
  logic [NR-1:0][DW-1:0] rd_bin;
  logic [NR-1:0][DW-1:0] rd_oh;

  logic [DW-1:0] model [DEPTH];
  logic          vld   [DEPTH];
  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  multiport_ram #(.NW(NW), .NR(NR), .DW(DW), .AW(AW), .ENC(ENC_BIN)) i_multiport_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_bin)
  );

  multiport_ram #(.NW(NW), .NR(NR), .DW(DW), .AW(AW), .ENC(ENC_ONEHOT)) i_multiport_ram_oh (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_oh)
  );

  task automatic chk(input string req, input string which, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, which, got, exp);
    end
  endtask

  // one clock: reads compared in the next cycle against the pre-write model
  task automatic step(input string req);
    logic [DW-1:0] exp_v [NR];
    logic          ok    [NR];
    for (int r = 0; r < NR; r++) begin
      ok[r]    = vld[rd_addr[r]];
      exp_v[r] = model[rd_addr[r]];
    end
    @(posedge clk);
    if (!rst)
      for (int w = 0; w < NW; w++)
        if (wr_en[w]) begin
          model[wr_addr[w]] = wr_data[w];
          vld[wr_addr[w]]   = 1'b1;
        end
    @(negedge clk);
    for (int r = 0; r < NR; r++)
      if (ok[r]) begin
        chk(req, "binary", rd_bin[r], exp_v[r]);
        chk(req, "onehot R6", rd_oh[r], exp_v[r]);
      end
  endtask

  task automatic wr1(input int port, input int a, input logic [DW-1:0] d);
    wr_en             = '0;
    wr_en[port]       = 1'b1;
    wr_addr[port]     = AW'(a);
    wr_data[port]     = d;
  endtask

  task automatic rd2(input int a0, input int a1);
    rd_addr[0] = AW'(a0);
    rd_addr[1] = AW'(a1);
  endtask

  task automatic t_fill_r2();
    for (int a = 0; a < DEPTH; a++) begin
      wr1(a % NW, a, DW'(16'h1000 + a * 7));
      step("R2");
    end
    wr_en = '0;
    for (int a = 0; a < DEPTH; a++) begin
      rd2(a, DEPTH - 1 - a);
      step("R2");
    end
  endtask

  task automatic t_parallel_r4();
    wr_en = '1;
    wr_addr[0] = 4'd1;  wr_data[0] = 16'hA001;
    wr_addr[1] = 4'd6;  wr_data[1] = 16'hA006;
    wr_addr[2] = 4'd11; wr_data[2] = 16'hA00B;
    step("R4");
    wr_en = '0;
    rd2(1, 6);  step("R4");
    rd2(11, 1); step("R4");
    step("R4");
  endtask

  task automatic t_override_r7();
    int order [6] = '{0, 2, 1, 0, 1, 2};
    for (int k = 0; k < 6; k++) begin
      wr1(order[k], 3, DW'(16'hC300 + k));
      rd2(3, 3);
      step("R7");
      wr_en = '0;
      step("R7");
    end
  endtask

  task automatic t_same_cycle_r3();
    wr1(1, 5, 16'h5151);
    rd2(5, 4);
    step("R3");
    wr_en = '0;
    step("R3");
    wr1(2, 5, 16'h5252);
    wr_en[0] = 1'b1; wr_addr[0] = 4'd4; wr_data[0] = 16'h4040;
    rd2(4, 5);
    step("R3");
    wr_en = '0;
    step("R3");
  endtask

  task automatic t_multi_read_r8();
    wr_en = '0;
    for (int a = 0; a < DEPTH; a++) begin
      rd2(a, a);
      step("R8");
      rd2(a, (a + 5) % DEPTH);
      step("R8");
    end
  endtask

  task automatic t_reset_r5();
    rst = 1'b1;
    wr_en = '1;
    wr_addr[0] = 4'd2; wr_data[0] = 16'hDEAD;
    wr_addr[1] = 4'd7; wr_data[1] = 16'hBEEF;
    wr_addr[2] = 4'd9; wr_data[2] = 16'hF00D;
    rd2(2, 7);
    step("R5");
    step("R5");
    wr_en = '0;
    rst = 1'b0;
    rd2(9, 2);
    step("R5");
    rd2(7, 9);
    step("R5");
    step("R5");
  endtask

  task automatic t_random_r1();
    for (int n = 0; n < 400; n++) begin
      int base = $urandom_range(0, DEPTH - 1);
      for (int w = 0; w < NW; w++) begin
        wr_en[w]   = $urandom_range(0, 1) == 1;
        wr_addr[w] = AW'((base + w * 5) % DEPTH);
        wr_data[w] = DW'($urandom);
      end
      rd2($urandom_range(0, DEPTH - 1), $urandom_range(0, DEPTH - 1));
      step("R1");
    end
    wr_en = '0;
    step("R1");
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = '0;
      vld[a]   = 1'b0;
    end
    @(negedge clk);
    step("R5");
    step("R5");
    rst = 1'b0;
    t_fill_r2();
    t_parallel_r4();
    t_override_r7();
    t_same_cycle_r3();
    t_multi_read_r8();
    t_reset_r5();
    t_random_r1();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule